// File: doc/BRIEF.md
# Memory Type Range Resolver

This block works out the effective cacheability type of a physical address range. A request carries a start address and an exclusive end address. The block checks that range against a small set of configuration registers and returns an 8-bit type code one clock later. The registers are a table of 88 type bytes that covers the first megabyte, a parameterised number of variable ranges (each a page-aligned base and mask pair), a default type, two enable bits and an upper memory limit that only applies above 4 GiB.

Within the first megabyte, the table entry is selected by the start address alone. Above it, every variable range is compared against both ends of the request at the same time. If any range covers one end of the request but not the other, the block returns a special "partially covered" code. Otherwise the types of all covering ranges are merged by a precedence rule that does not depend on register order. When no range matches, the block returns either write-back (for the region between 4 GiB and the upper limit) or the default type. A single write port loads the registers.

Top module: `mtr_resolver`

## Requirements
- R1: A request with `req_valid` high at a clock edge gives `rsp_valid` high after that edge, carrying the result. With no request, `rsp_valid` is low after the edge and `rsp_type` holds its last value. After reset, `rsp_valid` is 0 and `rsp_type` is 0x00.
- R2: When both enable bits are 0, the result is 0xFF.
- R3: The end address is exclusive. A range whose exclusive end sits exactly on a variable range's upper boundary counts as fully inside that range.
- R4: When the table is built in (HAS_FIXED), enable bit 0 is set and start < 0x100000, the result is table byte k. The end address is ignored. k = start>>16 below 0x80000; k = 8 + ((start-0x80000)>>14) from 0x80000 to 0xBFFFF; k = 24 + ((start-0xC0000)>>12) from 0xC0000 to 0xFFFFF.
- R5: Outside the table path, when enable bit 1 is 0, the result is the default type.
- R6: A variable range takes part only when bit 11 of its mask word is 1. An address matches it when (addr & mask) == (base & mask), with both base and mask stored with their low 12 bits cleared.
- R7: When variable ranges are enabled and any participating range matches exactly one of start and inclusive end, the result is 0xFE. This takes priority over every match.
- R8: A variable range's type is bits [7:0] of its base word.
- R9: Matching types merge as follows. Any 0x00 (uncached) gives 0x00. If all matching types are equal, the result is that type. A mix of only 0x06 (write-back) and 0x04 (write-through) gives 0x04. Any other mix gives 0x00.
- R10: With no match, if start >= 2^32 and the inclusive end is below the upper limit, the result is 0x06. Otherwise the result is the default type.
- R11: A write to the upper limit keeps only the bits set in 0xFFFF_FF80_0000, so bits [22:0] read as zero.
- R12: Register map (`cfg_addr`):
  - 0x00 to 0x57: table byte, written from data[7:0].
  - 0x60: default type from data[7:0]; enable bit 0 from data[8]; enable bit 1 from data[9].
  - 0x61: upper limit.
  - 0x80 + 2i: base word of range i (address in data[ADDR_W-1:12], type in data[7:0]).
  - 0x81 + 2i: mask word of range i (mask in data[ADDR_W-1:12], participate bit in data[11]).
  
  A request in the same cycle as a write sees the configuration from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register select |
| cfg_wdata | input | ADDR_W | Configuration write data |
| req_valid | input | 1 | Lookup request |
| req_start | input | ADDR_W | First byte address of the range |
| req_end | input | ADDR_W | Exclusive end address of the range |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_type | output | 8 | Resolved type or status code |

## Verification
The assertions assume that every request has an exclusive end strictly above its start, so the inclusive end never wraps. They also assume that ADDR_W is wider than 32 bits, so the 4 GiB test is meaningful. The stimulus always forms the end as the start plus a positive offset and keeps starts below 2^39, so the end cannot leave the address space. Random variable ranges are given power-of-two sizes at aligned bases, so that the partial-coverage checks see clean boundaries.

// File: rtl/mtr_pkg.sv
`timescale 1ns/1ps
package mtr_pkg;
    localparam logic [7:0] MT_UC    = 8'h00;
    localparam logic [7:0] MT_WT    = 8'h04;
    localparam logic [7:0] MT_WB    = 8'h06;
    localparam logic [7:0] MT_SPLIT = 8'hFE;
    localparam logic [7:0] MT_OFF   = 8'hFF;
    localparam int         FIX_N    = 88;
    localparam logic [7:0] CFG_CTRL = 8'h60;
    localparam logic [7:0] CFG_TOM2 = 8'h61;
    localparam logic [63:0] TOM2_KEEP = 64'h0000_FFFF_FF80_0000;

    // Table slot for an address below 1 MiB: 64K, 16K and 4K granules.
    function automatic logic [6:0] fix_index(input logic [19:0] a);
        if (!a[19])
            return {4'd0, a[18:16]};
        else if (!a[18])
            return 7'd8 + {3'd0, a[17:14]};
        else
            return 7'd24 + {1'b0, a[17:12]};
    endfunction
endpackage

// File: rtl/mtr_cfg_regs.sv
`timescale 1ns/1ps
module mtr_cfg_regs import mtr_pkg::*; #(
    parameter int ADDR_W  = 40,
    parameter int NUM_VAR = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [7:0]                        addr,
    input  logic [ADDR_W-1:0]                 wdata,
    output logic [FIX_N-1:0][7:0]             fix_tbl,
    output logic [7:0]                        dflt,
    output logic [1:0]                        en,
    output logic [ADDR_W-1:0]                 tom2,
    output logic [NUM_VAR-1:0][ADDR_W-1:0]    base,
    output logic [NUM_VAR-1:0][7:0]           vtype,
    output logic [NUM_VAR-1:0][ADDR_W-1:0]    mask,
    output logic [NUM_VAR-1:0]                vld
);
    localparam logic [ADDR_W-1:0] LIM_KEEP = ADDR_W'(TOM2_KEEP);

    typedef struct packed {
        logic [FIX_N-1:0][7:0]          fix;
        logic [7:0]                     dflt;
        logic [1:0]                     en;
        logic [ADDR_W-1:0]              tom2;
        logic [NUM_VAR-1:0][ADDR_W-1:0] base;
        logic [NUM_VAR-1:0][7:0]        vtype;
        logic [NUM_VAR-1:0][ADDR_W-1:0] mask;
        logic [NUM_VAR-1:0]             vld;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (addr < 8'(FIX_N)) begin
                cfg_d.fix[addr[6:0]] = wdata[7:0];
            end else if (addr == CFG_CTRL) begin
                cfg_d.dflt = wdata[7:0];
                cfg_d.en   = wdata[9:8];
            end else if (addr == CFG_TOM2) begin
                cfg_d.tom2 = wdata & LIM_KEEP;
            end else if (addr[7]) begin
                for (int i = 0; i < NUM_VAR; i++) begin
                    if (addr[6:1] == 6'(i)) begin
                        if (addr[0]) begin
                            cfg_d.mask[i] = {wdata[ADDR_W-1:12], 12'h000};
                            cfg_d.vld[i]  = wdata[11];
                        end else begin
                            cfg_d.base[i]  = {wdata[ADDR_W-1:12], 12'h000};
                            cfg_d.vtype[i] = wdata[7:0];
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign fix_tbl = cfg_q.fix;
    assign dflt    = cfg_q.dflt;
    assign en      = cfg_q.en;
    assign tom2    = cfg_q.tom2;
    assign base    = cfg_q.base;
    assign vtype   = cfg_q.vtype;
    assign mask    = cfg_q.mask;
    assign vld     = cfg_q.vld;
endmodule

// File: rtl/mtr_var_match.sv
`timescale 1ns/1ps
module mtr_var_match #(
    parameter int ADDR_W = 40
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] mask,
    input  logic              vld,
    input  logic [ADDR_W-1:0] first,
    input  logic [ADDR_W-1:0] last,
    output logic              hit,
    output logic              split
);
    logic first_in, last_in;
    assign first_in = ((first & mask) == (base & mask));
    assign last_in  = ((last & mask) == (base & mask));
    assign hit      = vld & first_in;
    assign split    = vld & (first_in ^ last_in);
endmodule

// File: rtl/mtr_merge.sv
`timescale 1ns/1ps
module mtr_merge import mtr_pkg::*; #(
    parameter int NUM_VAR = 4
) (
    input  logic [NUM_VAR-1:0]      hit,
    input  logic [NUM_VAR-1:0][7:0] vtype,
    output logic                    any_hit,
    output logic [7:0]              merged
);
    logic       has_uc, only_wbwt;
    logic [7:0] or_t, and_t;

    // Order-free reduction: equal types leave OR and AND identical.
    always_comb begin
        has_uc    = 1'b0;
        only_wbwt = 1'b1;
        or_t      = 8'h00;
        and_t     = 8'hFF;
        for (int i = 0; i < NUM_VAR; i++) begin
            if (hit[i]) begin
                or_t  = or_t | vtype[i];
                and_t = and_t & vtype[i];
                if (vtype[i] == MT_UC) has_uc = 1'b1;
                if (vtype[i] != MT_WB && vtype[i] != MT_WT) only_wbwt = 1'b0;
            end
        end
        if (has_uc)              merged = MT_UC;
        else if (or_t == and_t)  merged = or_t;
        else if (only_wbwt)      merged = MT_WT;
        else                     merged = MT_UC;
    end

    assign any_hit = |hit;
endmodule

// File: rtl/mtr_resolver.sv
`timescale 1ns/1ps
module mtr_resolver import mtr_pkg::*; #(
    parameter int ADDR_W    = 40,
    parameter int NUM_VAR   = 4,
    parameter bit HAS_FIXED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_end,
    output logic              rsp_valid,
    output logic [7:0]        rsp_type
);
    typedef struct packed {
        logic       valid;
        logic [7:0] rtype;
    } rsp_t;

    logic [FIX_N-1:0][7:0]          fix_w;
    logic [7:0]                     dflt_w;
    logic [1:0]                     en_w;
    logic [ADDR_W-1:0]              tom2_w;
    logic [NUM_VAR-1:0][ADDR_W-1:0] base_w, mask_w;
    logic [NUM_VAR-1:0][7:0]        vtype_w;
    logic [NUM_VAR-1:0]             vld_w, hit_w, split_w;
    logic [ADDR_W-1:0]              end_inc;
    logic                           use_fixed, any_split, any_hit, above_4g;
    logic [7:0]                     fix_type, merged, result;
    rsp_t                           rsp_d, rsp_q;

    mtr_cfg_regs #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .fix_tbl(fix_w), .dflt(dflt_w), .en(en_w), .tom2(tom2_w),
        .base(base_w), .vtype(vtype_w), .mask(mask_w), .vld(vld_w)
    );

    assign end_inc = req_end - ADDR_W'(1);

    for (genvar g = 0; g < NUM_VAR; g++) begin : g_rng
        mtr_var_match #(.ADDR_W(ADDR_W)) u_match (
            .base(base_w[g]), .mask(mask_w[g]), .vld(vld_w[g]),
            .first(req_start), .last(end_inc),
            .hit(hit_w[g]), .split(split_w[g])
        );
    end

    mtr_merge #(.NUM_VAR(NUM_VAR)) u_merge (
        .hit(hit_w), .vtype(vtype_w), .any_hit(any_hit), .merged(merged)
    );

    assign any_split = |split_w;
    assign above_4g  = |req_start[ADDR_W-1:32];
    assign use_fixed = HAS_FIXED && en_w[0] && (req_start[ADDR_W-1:20] == '0);
    assign fix_type  = fix_w[fix_index(req_start[19:0])];

    always_comb begin
        if (en_w == 2'b00)                      result = MT_OFF;
        else if (use_fixed)                     result = fix_type;
        else if (!en_w[1])                      result = dflt_w;
        else if (any_split)                     result = MT_SPLIT;
        else if (any_hit)                       result = merged;
        else if (above_4g && end_inc < tom2_w)  result = MT_WB;
        else                                    result = dflt_w;
    end

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) rsp_d.rtype = result;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_type  = rsp_q.rtype;
endmodule

// File: rtl/mtr_resolver_chk.sv
`timescale 1ns/1ps
module mtr_resolver_chk import mtr_pkg::*; (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        rsp_valid,
    input logic [7:0]  rsp_type,
    input logic [1:0]  en,
    input logic        use_fixed,
    input logic [7:0]  fix_type,
    input logic        any_split,
    input logic        cfg_we,
    input logic [7:0]  cfg_addr,
    input logic [22:0] tom2_lo
);
    // R1
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R1
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R2
    all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && en == 2'b00) |=> (rsp_type == MT_OFF));
    // R4
    table_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && use_fixed) |=> (rsp_type == $past(fix_type)));
    // R7
    straddle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && en[1] && !use_fixed && any_split) |=> (rsp_type == MT_SPLIT));
    // R11
    limit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == CFG_TOM2) |=> (tom2_lo == '0));
endmodule

bind mtr_resolver mtr_resolver_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
    .rsp_type(rsp_type), .en(en_w), .use_fixed(use_fixed), .fix_type(fix_type),
    .any_split(any_split), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .tom2_lo(tom2_w[22:0])
);

// File: tb/mtr_resolver_test.sv
`timescale 1ns/1ps
module mtr_resolver_test;
    localparam int AW = 40;
    localparam int NV = 4;
    localparam longint unsigned AMASK = (64'd1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_start = '0;
    logic [AW-1:0] req_end = '0;
    logic          rsp_valid;
    logic [7:0]    rsp_type;

    int errors = 0;
    int checks = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;
    string cur_tag = "R1";

    // reference model state
    byte unsigned     fix_m [88];
    byte unsigned     dflt_m, vt_m [NV];
    bit [1:0]         en_m;
    bit               vld_m [NV];
    longint unsigned  tom2_m, base_m [NV], mask_m [NV];
    bit               exp_valid = 1'b0;
    byte unsigned     exp_type = 0;
    string            exp_tag = "R1";

    mtr_resolver #(.ADDR_W(AW), .NUM_VAR(NV), .HAS_FIXED(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_start(req_start),
        .req_end(req_end), .rsp_valid(rsp_valid), .rsp_type(rsp_type)
    );

    always #2 clk = ~clk;

    function automatic byte unsigned ref_lookup(longint unsigned s, longint unsigned e);
        longint unsigned ei = (e - 1) & AMASK;
        byte unsigned found [$];
        int k;
        bit same, wbwt;
        if (en_m == 2'b00) return 8'hFF;
        if (en_m[0] && s < 64'h10_0000) begin
            if (s < 64'h8_0000)      k = int'(s / 65536);
            else if (s < 64'hC_0000) k = 8 + int'((s - 64'h8_0000) / 16384);
            else                     k = 24 + int'((s - 64'hC_0000) / 4096);
            return fix_m[k];
        end
        if (!en_m[1]) return dflt_m;
        for (int i = 0; i < NV; i++)
            if (vld_m[i] && (((s & mask_m[i]) == (base_m[i] & mask_m[i])) !=
                             ((ei & mask_m[i]) == (base_m[i] & mask_m[i]))))
                return 8'hFE;
        for (int i = 0; i < NV; i++)
            if (vld_m[i] && ((s & mask_m[i]) == (base_m[i] & mask_m[i])))
                found.push_back(vt_m[i]);
        if (found.size() == 0) begin
            if (s >= 64'h1_0000_0000 && ei < tom2_m) return 8'h06;
            return dflt_m;
        end
        same = 1'b1; wbwt = 1'b1;
        foreach (found[j]) begin
            if (found[j] == 8'h00) return 8'h00;
            if (found[j] != found[0]) same = 1'b0;
            if (found[j] != 8'h04 && found[j] != 8'h06) wbwt = 1'b0;
        end
        if (same) return found[0];
        if (wbwt) return 8'h04;
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_valid = 1'b0; exp_type = 0; exp_tag = "R1";
            foreach (fix_m[i]) fix_m[i] = 0;
            dflt_m = 0; en_m = 0; tom2_m = 0;
            for (int i = 0; i < NV; i++) begin
                vt_m[i] = 0; vld_m[i] = 0; base_m[i] = 0; mask_m[i] = 0;
            end
        end else begin
            exp_valid = req_valid;
            if (req_valid) begin
                exp_type = ref_lookup(64'(req_start), 64'(req_end));
                exp_tag  = cur_tag;
            end else begin
                exp_tag = "R1";
            end
            if (cfg_we) begin
                if (cfg_addr < 8'd88) fix_m[cfg_addr] = cfg_wdata[7:0];
                else if (cfg_addr == 8'h60) begin
                    dflt_m = cfg_wdata[7:0]; en_m = cfg_wdata[9:8];
                end else if (cfg_addr == 8'h61)
                    tom2_m = 64'(cfg_wdata) & 64'hFF_FF80_0000;
                else if (cfg_addr[7] && int'(cfg_addr[6:1]) < NV) begin
                    if (cfg_addr[0]) begin
                        mask_m[cfg_addr[6:1]] = 64'(cfg_wdata) & ~64'hFFF;
                        vld_m[cfg_addr[6:1]]  = cfg_wdata[11];
                    end else begin
                        base_m[cfg_addr[6:1]] = 64'(cfg_wdata) & ~64'hFFF;
                        vt_m[cfg_addr[6:1]]   = cfg_wdata[7:0];
                    end
                end
            end
        end
    end

    task automatic check(string tag, longint unsigned act, longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            check("R1", 64'(rsp_valid), 64'(exp_valid));
            check(exp_tag, 64'(rsp_type), 64'(exp_type));
        end
    end

    task automatic wr(input logic [7:0] a, input longint unsigned d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = AW'(d);
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic look(input longint unsigned s, input longint unsigned e, input string tag);
        cur_tag = tag; req_valid = 1'b1; req_start = AW'(s); req_end = AW'(e);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    function automatic longint unsigned msk(int sh);
        return (AMASK & ~((64'd1 << sh) - 1)) | 64'h800;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        cmp_on = 1'b1;             // R1 reset state compared while rst_n low
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        look(64'h1000, 64'h2000, "R2");
        look(64'h1_0000_0000, 64'h1_0000_1000, "R2");
        for (int k = 0; k < 88; k++) wr(8'(k), longint'((k * 3 + 1) & 255));
        wr(8'h60, 64'h105);        // table on, variable off, default 5
        look(64'h0, 64'hFFFF_0000, "R4");
        look(64'h7_FFFF, 64'h8_0001, "R4");
        look(64'h8_0000, 64'h8_1000, "R4");
        look(64'hB_FFFF, 64'hC_0000, "R4");
        look(64'hC_0000, 64'hC_1000, "R4");
        look(64'hF_F000, 64'h1000_0000, "R4");
        look(64'h10_0000, 64'h10_1000, "R5");
        wr(8'h60, 64'h305);        // both on
        wr(8'h80, 64'h1000_0006);  // range 0: 1 MiB write-back
        wr(8'h81, msk(20));
        look(64'h1000_0000, 64'h1010_0000, "R3");
        look(64'h1000_0000, 64'h1010_0001, "R7");
        look(64'h0FFF_F000, 64'h1000_1000, "R7");
        look(64'h2000_0000, 64'h2000_1000, "R10");
        wr(8'h82, 64'h1000_0004);  // range 1: 256 KiB write-through
        wr(8'h83, msk(18));
        look(64'h1000_1000, 64'h1000_2000, "R9");
        look(64'h1008_0000, 64'h1008_1000, "R6");
        wr(8'h84, 64'h1000_0000);  // range 2: uncached
        wr(8'h85, msk(16));
        look(64'h1000_0000, 64'h1000_1000, "R9");
        wr(8'h84, 64'h1000_0001);
        look(64'h1000_0000, 64'h1000_1000, "R9");
        wr(8'h85, msk(16) & ~64'h800);  // range 2 no longer participates
        look(64'h1000_0000, 64'h1000_1000, "R6");
        wr(8'h86, 64'h3000_0005);  // range 3: type 5
        wr(8'h87, msk(12));
        look(64'h3000_0000, 64'h3000_1000, "R8");
        look(64'h3000_0800, 64'h3000_1800, "R7");
        wr(8'h61, 64'h2_0000_0000);
        look(64'h1_0000_0000, 64'h1_0000_1000, "R10");
        look(64'h1_FFFF_F000, 64'h2_0000_1000, "R10");
        look(64'hF000_0000, 64'hF000_1000, "R10");
        wr(8'h61, 64'h1_0040_0000);
        look(64'h1_0000_0000, 64'h1_0000_1000, "R11");
        // R12: write and request in the same cycle
        cur_tag = "R12"; req_valid = 1'b1; req_start = AW'(64'h3000_0000); req_end = AW'(64'h3000_1000);
        cfg_we = 1'b1; cfg_addr = 8'h86; cfg_wdata = AW'(64'h3000_0006);
        @(posedge clk); #1;
        cfg_we = 1'b0;
        look(64'h3000_0000, 64'h3000_1000, "R12");
        wr(8'h60, 64'h005);
        look(64'h3000_0000, 64'h3000_1000, "R2");
        wr(8'h60, 64'h205);
        look(64'h1000, 64'h2000, "R5");
        // random phase
        for (int n = 0; n < 3000; n++) begin
            int unsigned r = $urandom;
            if (r[2:0] == 3'd0) begin
                int sh = 12 + int'($urandom % 12);
                int idx = int'($urandom % NV);
                byte unsigned t;
                case ($urandom % 5)
                    0: t = 0; 1: t = 1; 2: t = 4; 3: t = 5; default: t = 6;
                endcase
                if ($urandom % 2 == 0)
                    wr(8'(8'h80 + 2 * idx), 64'h1000_0000 + (longint'($urandom % 16) << sh) + t);
                else
                    wr(8'(8'h81 + 2 * idx), msk(sh) & ~(($urandom % 6 == 0) ? 64'h800 : 64'h0));
            end else if (r[5:0] == 6'd1) begin
                wr(8'h60, longint'($urandom % 1024));
            end else if (r[5:0] == 6'd2) begin
                wr(8'h61, (longint'($urandom) << 4) & AMASK);
            end else begin
                longint unsigned s;
                case ($urandom % 4)
                    0: s = longint'($urandom % 32'h10_0000);
                    1: s = 64'h1000_0000 + longint'($urandom % 32'h200_0000);
                    2: s = 64'h1_0000_0000 + (longint'($urandom) << 2);
                    default: s = longint'($urandom);
                endcase
                look(s, s + 1 + longint'($urandom % 32'h40_0000), "R9");
            end
        end
        repeat (2) @(posedge clk);
        #1;
        finish_run();
    end

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end
endmodule